// File: doc/BRIEF.md
# Staged-Update Phase-Accumulator Oscillator

The block is a numerically controlled oscillator for a larger synthesis chain. A 32-bit accumulator adds a tuning word on every clock, so the output frequency is the tuning word times the clock rate divided by 2^32. A coarse phase offset is added to the top of the accumulator, and the block presents a truncated 14-bit phase for a later lookup stage, plus a square wave taken from the phase MSB.

New tuning words and phase bytes go first into shadow registers and have no effect on the output until they are applied. There are two ways to apply them. One is a one-cycle update strobe. The other is any level change on the rate-select pin, which applies them after a programmable delay measured in clock cycles. The rate-select pin also sets the multiplier: when it is low, the accumulator steps by four times the active word. When it is high, which is its default, the word is used as written. The word is not range checked, and any overflow wraps modulo 2^32.

Top module: `nco_staged_core`

## Requirements
- R1: Each rising clock edge adds the effective step to the 32-bit accumulator, modulo 2^32. The effective step is the active tuning word when rate_sel is high. A word written to the active register through an update at edge j first contributes at edge j+1.
- R2: phase_out equals accumulator bits [31:18] plus the active 5-bit offset placed in bits [13:9], modulo 2^14. This value is visible in the cycle after the accumulator edge. One offset step is 1/32 of a cycle (11.25 degrees).
- R3: sq_out always equals bit 13 of the expected phase_out value.
- R4: freq_wr and phase_wr load only the shadow registers. The active values change only at an update edge, which is either a cycle with upd high or a delayed apply from R6. At that edge the active values take the shadow contents as they were before the edge, so a write in the same cycle is not included.
- R5: rate_sel passes through a two-flop synchroniser. Call edge e0 the first rising edge that samples a new level. The new multiplier setting is used from edge e0+2 onward. While the pin is low, the step is the active word shifted left by two bits, with the top two bits dropped, so 0xC0000001 steps by 4.
- R6: A rising or falling change of rate_sel applies the shadow values at edge e0+UPD_DELAY+2, where e0 is defined as in R5.
- R7: While rst_n is low, the accumulator clears to 0. Both the shadow and active tuning words load DEF_FREQ, both offsets load bits [7:3] of DEF_PHASE, and any pending delayed apply is cancelled. The synchroniser assumes rate_sel is high.
- R8: The offset is taken only from phase_in bits [7:3], and bits [2:0] have no effect. For example, the bytes 0x2F and 0x28 give the same phase_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| freq_wr | input | 1 | Load freq_in into the shadow tuning word |
| freq_in | input | 32 | Tuning word to stage |
| phase_wr | input | 1 | Load phase_in bits [7:3] into the shadow offset |
| phase_in | input | 8 | Phase byte to stage |
| upd | input | 1 | Apply the shadow values to the active registers |
| rate_sel | input | 1 | High: step by the word as written; low: step by four times the word; any change also schedules a delayed apply |
| phase_out | output | 14 | Truncated phase with the offset added |
| sq_out | output | 1 | Square wave, the MSB of phase_out |

## Verification
A cycle-accurate reference model tracks the accumulator and is compared against the outputs on every cycle.

The tuning words are chosen to separate different faults:
- A large word with a ragged bit pattern exposes carries lost below bit 18.
- A tiny word that moves only the low phase bits exposes truncation at the wrong position.
- A times-four word whose shifted form overflows shows whether the overflow bits are dropped.

Staging is tested by writing shadows and holding without an update, and by writing in the same cycle as the update. These tell a design that latches before the write from one that latches after it. Mode-pin changes in both directions are checked cycle by cycle against the exact delayed-apply edge. Phase bytes that differ only in their low three bits must give the same output.

// File: rtl/nco_pkg.sv
package nco_pkg;

   // Level of the rate-select pin and the stepping mode it picks
   typedef enum logic {
      RATE_X4 = 1'b0,
      RATE_X1 = 1'b1
   } rate_e;

   // Clamp helper used for parameters that must be at least a floor value
   function automatic int unsigned at_least(input int unsigned v, input int unsigned floor_v);
      return (v < floor_v) ? floor_v : v;
   endfunction

endpackage

// File: rtl/nco_rate_tracker.sv
module nco_rate_tracker
   import nco_pkg::*;
#(
   parameter int unsigned UPD_DELAY   = 3_400_000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rate_sel,
   output logic x4_sel,
   output logic fire
);

   localparam int unsigned SYNC_N    = at_least(SYNC_STAGES, 2);
   localparam int unsigned EFF_DELAY = at_least(UPD_DELAY, 1);
   localparam int unsigned CNT_W     = $clog2(EFF_DELAY + 1);

   logic [SYNC_N-1:0] sync_q;
   logic              last_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              lvl;
   logic              change_seen;

   // Synchroniser chain, idling at the default high level
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= {SYNC_N{RATE_X1}};
         last_q <= RATE_X1;
      end else begin
         sync_q <= {sync_q[SYNC_N-2:0], rate_sel};
         last_q <= sync_q[SYNC_N-1];
      end
   end

   assign lvl         = sync_q[SYNC_N-1];
   assign change_seen = lvl ^ last_q;
   assign x4_sel      = (lvl == RATE_X4);

   // Delay counter: armed by any change, restarts on another one
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (change_seen) begin
         cnt_q <= CNT_W'(EFF_DELAY);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign fire = (cnt_q == CNT_W'(1)) && !change_seen;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(EFF_DELAY)); // R6

   AST_FIRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire); // R6

endmodule

// File: rtl/nco_stage.sv
module nco_stage #(
   parameter int unsigned            ACC_W     = 32,
   parameter int unsigned            PH_IN_W   = 8,
   parameter int unsigned            OFS_W     = 5,
   parameter logic [ACC_W-1:0]       DEF_FREQ  = '0,
   parameter logic [PH_IN_W-1:0]     DEF_PHASE = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               freq_wr,
   input  logic [ACC_W-1:0]   freq_in,
   input  logic               phase_wr,
   input  logic [PH_IN_W-1:0] phase_in,
   input  logic               apply,
   output logic [ACC_W-1:0]   sh_freq,
   output logic [ACC_W-1:0]   act_freq,
   output logic [OFS_W-1:0]   act_ofs
);

   localparam int unsigned LOW_W = PH_IN_W - OFS_W;
   localparam logic [OFS_W-1:0] DEF_OFS = DEF_PHASE[PH_IN_W-1 -: OFS_W];

   logic [OFS_W-1:0] sh_ofs;
   logic [OFS_W-1:0] ofs_field;

   assign ofs_field = phase_in[PH_IN_W-1 -: OFS_W];

   generate
      if (LOW_W > 0) begin : g_low_drop
         logic unused_low_bits;
         assign unused_low_bits = ^phase_in[LOW_W-1:0];
      end
   endgenerate

   // Shadow registers: written by software-side strobes only
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_freq <= DEF_FREQ;
         sh_ofs  <= DEF_OFS;
      end else begin
         if (freq_wr)  sh_freq <= freq_in;
         if (phase_wr) sh_ofs  <= ofs_field;
      end
   end

   // Active registers: copy the shadow contents on an apply edge
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_freq <= DEF_FREQ;
         act_ofs  <= DEF_OFS;
      end else if (apply) begin
         act_freq <= sh_freq;
         act_ofs  <= sh_ofs;
      end
   end

   AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !apply |=> ($stable(act_freq) && $stable(act_ofs))); // R4

   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !freq_wr |=> $stable(sh_freq)); // R4

endmodule

// File: rtl/nco_accum.sv
module nco_accum #(
   parameter int unsigned ACC_W      = 32,
   parameter int unsigned OUT_W      = 14,
   parameter int unsigned OFS_W      = 5,
   parameter int unsigned MULT_SHIFT = 2,
   parameter bit          OUT_REG    = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ACC_W-1:0] act_freq,
   input  logic [OFS_W-1:0] act_ofs,
   input  logic             x4_sel,
   output logic [OUT_W-1:0] phase_out,
   output logic             sq_out
);

   localparam int unsigned OFS_POS = OUT_W - OFS_W;

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] step;
   logic [OUT_W-1:0] phase_sum;

   // Effective step: the shifted variant exists only for a nonzero shift
   generate
      if (MULT_SHIFT == 0) begin : g_no_mult
         logic unused_sel;
         assign unused_sel = x4_sel;
         assign step       = act_freq;
      end else begin : g_mult
         assign step = x4_sel ? ACC_W'(act_freq << MULT_SHIFT) : act_freq;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_q + step;
   end

   assign phase_sum = acc_q[ACC_W-1 -: OUT_W] + (OUT_W'(act_ofs) << OFS_POS);

   generate
      if (OUT_REG) begin : g_out_reg
         logic [OUT_W-1:0] ph_q;
         always_ff @(posedge clk) begin
            if (!rst_n) ph_q <= '0;
            else        ph_q <= phase_sum;
         end
         assign phase_out = ph_q;
      end else begin : g_out_comb
         assign phase_out = phase_sum;
      end
   endgenerate

   assign sq_out = phase_out[OUT_W-1];

   AST_ZERO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (step == '0) |=> $stable(acc_q)); // R1

endmodule

// File: rtl/nco_staged_core.sv
module nco_staged_core
   import nco_pkg::*;
#(
   parameter int unsigned        ACC_W       = 32,
   parameter int unsigned        PH_IN_W     = 8,
   parameter int unsigned        OFS_W       = 5,
   parameter int unsigned        OUT_W       = 14,
   parameter int unsigned        MULT_SHIFT  = 2,
   parameter int unsigned        UPD_DELAY   = 3_400_000,
   parameter int unsigned        SYNC_STAGES = 2,
   parameter bit                 OUT_REG     = 1'b0,
   parameter logic [ACC_W-1:0]   DEF_FREQ    = '0,
   parameter logic [PH_IN_W-1:0] DEF_PHASE   = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               freq_wr,
   input  logic [ACC_W-1:0]   freq_in,
   input  logic               phase_wr,
   input  logic [PH_IN_W-1:0] phase_in,
   input  logic               upd,
   input  logic               rate_sel,
   output logic [OUT_W-1:0]   phase_out,
   output logic               sq_out
);

   logic             x4_sel;
   logic             fire;
   logic             apply;
   logic [ACC_W-1:0] sh_freq;
   logic [ACC_W-1:0] act_freq;
   logic [OFS_W-1:0] act_ofs;

   nco_rate_tracker #(
      .UPD_DELAY   (UPD_DELAY),
      .SYNC_STAGES (SYNC_STAGES)
   ) i_rate (
      .clk      (clk),
      .rst_n    (rst_n),
      .rate_sel (rate_sel),
      .x4_sel   (x4_sel),
      .fire     (fire)
   );

   assign apply = upd | fire;

   nco_stage #(
      .ACC_W     (ACC_W),
      .PH_IN_W   (PH_IN_W),
      .OFS_W     (OFS_W),
      .DEF_FREQ  (DEF_FREQ),
      .DEF_PHASE (DEF_PHASE)
   ) i_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .freq_wr  (freq_wr),
      .freq_in  (freq_in),
      .phase_wr (phase_wr),
      .phase_in (phase_in),
      .apply    (apply),
      .sh_freq  (sh_freq),
      .act_freq (act_freq),
      .act_ofs  (act_ofs)
   );

   nco_accum #(
      .ACC_W      (ACC_W),
      .OUT_W      (OUT_W),
      .OFS_W      (OFS_W),
      .MULT_SHIFT (MULT_SHIFT),
      .OUT_REG    (OUT_REG)
   ) i_accum (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_freq  (act_freq),
      .act_ofs   (act_ofs),
      .x4_sel    (x4_sel),
      .phase_out (phase_out),
      .sq_out    (sq_out)
   );

   AST_UPD_TAKES_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> (act_freq == $past(sh_freq))); // R4

endmodule

// File: tb/test_nco_staged_core.sv
`timescale 1ns/1ps
module test_nco_staged_core;

   localparam int          D      = 12;
   localparam logic [31:0] DEF_F  = 32'h0010_0000;
   localparam logic [7:0]  DEF_P  = 8'h40;
   localparam int          NVEC   = 6;

   // {freq[48:17], phase byte[16:9], rate_sel[8], hold cycles[7:0]}
   localparam logic [48:0] VEC [NVEC] = '{
      {32'h0100_0000, 8'h00, 1'b1, 8'd20},
      {32'h0004_0000, 8'h28, 1'b1, 8'd24},
      {32'h1234_5678, 8'hFF, 1'b1, 8'd30},
      {32'h2000_0000, 8'h47, 1'b0, 8'd20},
      {32'hC000_0001, 8'h80, 1'b0, 8'd20},
      {32'h0000_0000, 8'h18, 1'b1, 8'd10}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        freq_wr = 1'b0;
   logic [31:0] freq_in = '0;
   logic        phase_wr = 1'b0;
   logic [7:0]  phase_in = '0;
   logic        upd = 1'b0;
   logic        rate_sel = 1'b1;
   logic [13:0] phase_out;
   logic        sq_out;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   nco_staged_core #(
      .UPD_DELAY (D),
      .DEF_FREQ  (DEF_F),
      .DEF_PHASE (DEF_P)
   ) i_nco_staged_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .freq_wr   (freq_wr),
      .freq_in   (freq_in),
      .phase_wr  (phase_wr),
      .phase_in  (phase_in),
      .upd       (upd),
      .rate_sel  (rate_sel),
      .phase_out (phase_out),
      .sq_out    (sq_out)
   );

   // Reference model built from the requirement timing
   logic [31:0] m_acc, m_act_f, m_sh_f;
   logic [4:0]  m_act_p, m_sh_p;
   logic        m_x4, x4_next;
   int          edge_no = 0;
   int          apply_edge = -1;
   int          x4_edge = -1;

   always @(posedge clk) begin
      edge_no++;
      if (!rst_n) begin
         m_acc      = '0;
         m_act_f    = DEF_F;
         m_sh_f     = DEF_F;
         m_act_p    = DEF_P[7:3];
         m_sh_p     = DEF_P[7:3];
         m_x4       = 1'b0;
         apply_edge = -1;
         x4_edge    = -1;
      end else begin
         m_acc = m_acc + (m_x4 ? {m_act_f[29:0], 2'b00} : m_act_f);
         if (upd || edge_no == apply_edge) begin
            m_act_f = m_sh_f;
            m_act_p = m_sh_p;
         end
         if (freq_wr)  m_sh_f = freq_in;
         if (phase_wr) m_sh_p = phase_in[7:3];
         if (edge_no == x4_edge) m_x4 = x4_next;
      end
   end

   task automatic check(input string tag);
      logic [13:0] want;
      want = m_acc[31:18] + {m_act_p, 9'b0};
      total++;
      if (phase_out !== want) begin
         bad++;
         $display("FAIL %s phase_out actual=%h expected=%h", tag, phase_out, want);
      end
      total++;
      if (sq_out !== want[13]) begin
         bad++;
         $display("FAIL R3 sq_out actual=%b expected=%b", sq_out, want[13]);
      end
   endtask

   task automatic step(input string tag);
      @(posedge clk);
      @(negedge clk);
      check(tag);
   endtask

   task automatic write_vals(input logic [31:0] f, input logic [7:0] p, input string tag);
      freq_wr = 1'b1; phase_wr = 1'b1; freq_in = f; phase_in = p;
      step(tag);
      freq_wr = 1'b0; phase_wr = 1'b0;
   endtask

   task automatic pulse_upd(input string tag);
      upd = 1'b1;
      step(tag);
      upd = 1'b0;
   endtask

   task automatic set_rate(input logic v);
      if (v != rate_sel) begin
         x4_next    = !v;
         x4_edge    = edge_no + 2;
         apply_edge = edge_no + D + 3;
      end
      rate_sel = v;
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [13:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R7 reset state");
      repeat (6) step("R1 default word");

      // Table-driven main function
      for (int i = 0; i < NVEC; i++) begin
         string t;
         t = VEC[i][8] ? "R1 R2" : "R5 x4";
         set_rate(VEC[i][8]);
         repeat (D + 6) step("R5 R6 rate change");
         write_vals(VEC[i][48:17], VEC[i][16:9], "R4 staged");
         repeat (4) step("R4 staged no effect");
         pulse_upd("R4 update");
         for (int c = 0; c < int'(VEC[i][7:0]); c++) step(t);
      end

      // Low phase bits ignored (active word is 0 now)
      write_vals(32'h0, 8'h2F, "R8");
      pulse_upd("R8");
      step("R8");
      held = phase_out;
      phase_wr = 1'b1; phase_in = 8'h28;
      step("R8");
      phase_wr = 1'b0;
      pulse_upd("R8");
      step("R8");
      total++;
      if (phase_out !== held) begin
         bad++;
         $display("FAIL R8 low bits changed output actual=%h expected=%h", phase_out, held);
      end

      // Write in the same cycle as the update: old shadow is taken
      write_vals(32'h0300_0000, 8'h10, "R4");
      freq_wr = 1'b1; freq_in = 32'h0780_0000; upd = 1'b1;
      step("R4 same-cycle write");
      freq_wr = 1'b0; upd = 1'b0;
      repeat (5) step("R4 same-cycle write");
      pulse_upd("R4");
      repeat (5) step("R4");

      // Falling then rising transition applies pending values after delay
      write_vals(32'h0800_0000, 8'h98, "R6");
      set_rate(1'b0);
      repeat (D + 8) step("R6 falling");
      write_vals(32'h0040_0000, 8'hE0, "R6");
      set_rate(1'b1);
      repeat (D + 8) step("R6 rising");

      // Reset in mid-run restores defaults
      write_vals(32'h1111_0000, 8'h08, "R7");
      rst_n = 1'b0;
      repeat (2) step("R7 in reset");
      rst_n = 1'b1;
      check("R7 after reset");
      repeat (6) step("R7 default word");

      finish_run();
   end

endmodule